// File: doc/BRIEF.md
# Memory-Mapped I/O Range Router

This block steers memory-mapped I/O requests. It holds eight programmable address windows. Each window has a base register and a limit register. For every request it compares the upper bits of the 40-bit address against all windows in parallel. When a window matches, the block reports where the request must go: a node number and a link number. It also reports whether a CPU write must travel as non-posted. Requests that match no window leave the hit flag low, so a default path elsewhere can take them.

Each window carries its own qualifiers:

- Separate read and write enables.
- A CPU-exclusion bit that hides the window from CPU-originated requests.
- A lock bit. Once set, it freezes both registers of that window until reset.

Software programs the windows through a simple register port. The port selects a window index and chooses either the base or the limit register. Writes to a locked window are discarded and flagged with a one-cycle pulse. When a window matches but its link field holds the reserved code, the block flags an error instead of routing the request.

Top module: `mmio_range_router`

## Requirements
- R1: After reset all base and limit registers read as zero, and all response outputs are low. A request then hits nothing.
- R2: A window matches when address bits 39:16 lie inclusively between base bits 31:8 and limit bits 31:8. The boundaries are:
  - An address whose upper field equals the base or the limit field hits.
  - One 64 KiB unit below the base misses.
  - One 64 KiB unit above the limit misses.
- R3: The base register controls access:
  - Base bit 0 enables matching for reads (req_is_write=0).
  - Base bit 1 enables matching for writes (req_is_write=1).
  - A request whose access kind is not enabled does not match.
- R4: When base bit 2 is set, requests with req_from_cpu=1 do not match that window. Other requests still match it.
- R5: When base bit 3 of a window is set, a write to that window's base (cfg_sel=0) or limit (cfg_sel=1) register leaves the stored value unchanged. Both read-back and routing keep the old value.
- R6: A register write aimed at a locked window raises cfg_wr_reject for exactly one cycle. A write to an unlocked window leaves cfg_wr_reject low.
- R7: On a hit, the outputs come from the matching window's limit register:
  - rsp_node is limit bits 2:0.
  - rsp_link is limit bits 5:4.
  - rsp_range is the window index.
- R8: When the matching window's link code is 2'b11, the request is not routed: rsp_error=1, rsp_hit=0, and rsp_node, rsp_link and rsp_range are 0.
- R9: rsp_nonposted is 1 only when all of these hold:
  - the request hits;
  - it is a write with req_from_cpu=1;
  - the matching window's limit bit 7 is set.
- R10: When several windows match, the lowest-numbered window decides the response.
- R11: Timing is fixed:
  - Response outputs and rsp_valid appear one cycle after the request is sampled. Without a request they are low.
  - cfg_rdata shows the selected register one cycle after cfg_rd_en and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_idx | input | 3 | Window index |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the limit register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| cfg_wr_reject | output | 1 | Pulse: write dropped because the window is locked |
| req_valid | input | 1 | Request present |
| req_addr | input | 40 | Request address |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_from_cpu | input | 1 | Request originates from a CPU |
| rsp_valid | output | 1 | Response slot corresponds to a request |
| rsp_hit | output | 1 | A window matched and the request is routed |
| rsp_error | output | 1 | A window matched but its link code is reserved |
| rsp_node | output | 3 | Destination node |
| rsp_link | output | 2 | Destination link |
| rsp_nonposted | output | 1 | CPU write must be issued as non-posted |
| rsp_range | output | 3 | Index of the deciding window |

## Verification
Every result sits exactly one register stage from its stimulus:
- A request presented before a rising edge produces its routing fields after that edge.
- A read strobe produces cfg_rdata after the same edge.
- A write to a locked window raises cfg_wr_reject after that edge and drops it after the next one.

The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the following falling edge. It samples cfg_wr_reject once more a full cycle later to confirm the pulse lasts only one cycle. Register writes take effect at the edge that samples them, so every routing check is issued after the write has completed.

// File: rtl/mmio_rt_pkg.sv
package mmio_rt_pkg;
    // Base register control bit positions
    localparam int unsigned RD_EN_BIT   = 0;
    localparam int unsigned WR_EN_BIT   = 1;
    localparam int unsigned CPU_DIS_BIT = 2;
    localparam int unsigned LOCK_BIT    = 3;
    localparam int unsigned CTL_W       = 3;   // bits of base used by the matcher

    // Limit register field positions
    localparam int unsigned NODE_LSB    = 0;
    localparam int unsigned NODE_W      = 3;
    localparam int unsigned LINK_LSB    = 4;
    localparam int unsigned LINK_W      = 2;
    localparam int unsigned NP_BIT      = 7;

    localparam logic [LINK_W-1:0] LINK_RESERVED = 2'b11;

    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/mmio_rt_match.sv
module mmio_rt_match
    import mmio_rt_pkg::*;
#(
    parameter int unsigned CMP_W = 24
) (
    input  logic [CMP_W-1:0] addr_fld,
    input  logic [CMP_W-1:0] lo_fld,
    input  logic [CMP_W-1:0] hi_fld,
    input  logic [CTL_W-1:0] ctl,
    input  logic             is_write,
    input  logic             from_cpu,
    output logic             match
);
    logic in_window;
    logic access_ok;
    logic requester_ok;

    always_comb begin
        in_window    = (addr_fld >= lo_fld) && (addr_fld <= hi_fld);
        access_ok    = is_write ? ctl[WR_EN_BIT] : ctl[RD_EN_BIT];
        requester_ok = !(from_cpu && ctl[CPU_DIS_BIT]);
        match        = in_window && access_ok && requester_ok;
    end
endmodule

// File: rtl/mmio_rt_prio.sv
module mmio_rt_prio #(
    parameter int unsigned N     = 8,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        // Scan downward so the lowest set bit is the last one written
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

    // The chosen index is requesting, and nothing below it requests
    always_comb begin
        if (any) begin
            p_pick_lowest_r10: assert (req[idx] &&
                ((req & ((N'(1) << idx) - N'(1))) == '0));
        end else begin
            p_none_means_idle_r10: assert (req == '0);
        end
    end
endmodule

// File: rtl/mmio_range_router.sv
module mmio_range_router
    import mmio_rt_pkg::*;
#(
    parameter int unsigned NUM_RANGES = 8,
    parameter int unsigned ADDR_W     = 40,
    parameter int unsigned GRAN_LOG2  = 16,
    parameter int unsigned REG_W      = 32,
    localparam int unsigned CMP_W     = ADDR_W - GRAN_LOG2,
    localparam int unsigned IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_rd_en,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              cfg_wr_reject,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_write,
    input  logic              req_from_cpu,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_error,
    output logic [NODE_W-1:0] rsp_node,
    output logic [LINK_W-1:0] rsp_link,
    output logic              rsp_nonposted,
    output logic [IDX_W-1:0]  rsp_range
);
    typedef struct packed {
        logic [NUM_RANGES-1:0][REG_W-1:0] base;
        logic [NUM_RANGES-1:0][REG_W-1:0] limit;
        logic [REG_W-1:0]                 rdata;
        logic                             reject;
        logic                             valid;
        logic                             hit;
        logic                             error;
        logic [NODE_W-1:0]                node;
        logic [LINK_W-1:0]                link;
        logic                             nonposted;
        logic [IDX_W-1:0]                 range;
    } state_t;

    state_t st_d, st_q;

    logic [CMP_W-1:0]      addr_fld;
    logic [GRAN_LOG2-1:0]  unused_addr_low;
    logic [NUM_RANGES-1:0] match_vec;
    logic [IDX_W-1:0]      win_idx;
    logic                  win_any;

    assign addr_fld        = req_addr[ADDR_W-1:GRAN_LOG2];
    assign unused_addr_low = req_addr[GRAN_LOG2-1:0];

    // One comparator per window
    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        mmio_rt_match #(.CMP_W(CMP_W)) u_match (
            .addr_fld (addr_fld),
            .lo_fld   (st_q.base[g][REG_W-1 -: CMP_W]),
            .hi_fld   (st_q.limit[g][REG_W-1 -: CMP_W]),
            .ctl      (st_q.base[g][CTL_W-1:0]),
            .is_write (req_is_write),
            .from_cpu (req_from_cpu),
            .match    (match_vec[g])
        );
    end

    mmio_rt_prio #(.N(NUM_RANGES)) u_prio (
        .req (match_vec),
        .idx (win_idx),
        .any (win_any)
    );

    logic [REG_W-1:0]  win_lim;
    logic [LINK_W-1:0] win_link;
    logic              link_bad;

    always_comb begin
        st_d        = st_q;
        st_d.reject = 1'b0;

        // Register port: a locked window drops the write and flags it
        if (cfg_wr_en) begin
            if (st_q.base[cfg_idx][LOCK_BIT]) begin
                st_d.reject = 1'b1;
            end else if (cfg_sel == SEL_LIMIT) begin
                st_d.limit[cfg_idx] = cfg_wdata;
            end else begin
                st_d.base[cfg_idx] = cfg_wdata;
            end
        end
        if (cfg_rd_en) begin
            st_d.rdata = (cfg_sel == SEL_LIMIT) ? st_q.limit[cfg_idx]
                                                : st_q.base[cfg_idx];
        end

        // Routing decision from the winning window
        win_lim  = st_q.limit[win_idx];
        win_link = win_lim[LINK_LSB +: LINK_W];
        link_bad = (win_link == LINK_RESERVED);

        st_d.valid     = req_valid;
        st_d.hit       = req_valid && win_any && !link_bad;
        st_d.error     = req_valid && win_any && link_bad;
        st_d.node      = st_d.hit ? win_lim[NODE_LSB +: NODE_W] : '0;
        st_d.link      = st_d.hit ? win_link : '0;
        st_d.range     = st_d.hit ? win_idx : '0;
        st_d.nonposted = st_d.hit && req_is_write && req_from_cpu && win_lim[NP_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata     = st_q.rdata;
    assign cfg_wr_reject = st_q.reject;
    assign rsp_valid     = st_q.valid;
    assign rsp_hit       = st_q.hit;
    assign rsp_error     = st_q.error;
    assign rsp_node      = st_q.node;
    assign rsp_link      = st_q.link;
    assign rsp_nonposted = st_q.nonposted;
    assign rsp_range     = st_q.range;

    // A reported error and a routed hit never coincide
    p_hit_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_error));

    // The reject pulse only follows a write strobe
    p_reject_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_reject |-> $past(cfg_wr_en));

    // Non-posted marking is reserved for CPU writes that were routed
    p_np_cpu_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_nonposted |-> (rsp_hit && $past(req_is_write && req_from_cpu)));

    // With no request in the slot nothing is reported
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_error && !rsp_nonposted));

    // A locked window keeps both registers frozen
    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_lock_chk
        logic             lock_bit;
        logic [REG_W-1:0] base_v;
        logic [REG_W-1:0] limit_v;
        assign lock_bit = st_q.base[g][LOCK_BIT];
        assign base_v   = st_q.base[g];
        assign limit_v  = st_q.limit[g];
        p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(lock_bit) |-> ($stable(base_v) && $stable(limit_v)));
    end
endmodule

// File: tb/mmio_range_router_bench.sv
module mmio_range_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_rd_en = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_wr_reject;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        req_is_write = 1'b0;
    logic        req_from_cpu = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_error, rsp_nonposted;
    logic [2:0]  rsp_node;
    logic [1:0]  rsp_link;
    logic [2:0]  rsp_range;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mmio_range_router u_mmio_range_router (
        .clk, .rst_n, .cfg_wr_en, .cfg_rd_en, .cfg_idx, .cfg_sel, .cfg_wdata,
        .cfg_rdata, .cfg_wr_reject, .req_valid, .req_addr, .req_is_write,
        .req_from_cpu, .rsp_valid, .rsp_hit, .rsp_error, .rsp_node, .rsp_link,
        .rsp_nonposted, .rsp_range
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_base(input logic [23:0] a, input logic lock,
                                            input logic cpud, input logic we, input logic re);
        return {a, 4'b0, lock, cpud, we, re};
    endfunction

    function automatic logic [31:0] mk_lim(input logic [23:0] a, input logic np,
                                           input logic [1:0] link, input logic [2:0] node);
        return {a, np, 1'b0, link, 1'b0, node};
    endfunction

    // Write; checks the reject pulse one cycle later and its drop a cycle after that
    task automatic cfg_write(input int idx, input bit sel, input logic [31:0] d, input bit exp_rej);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_idx = 3'(idx); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        chk("R6 reject pulse", 64'(cfg_wr_reject), 64'(exp_rej));
        @(negedge clk);
        chk("R6 reject one cycle", 64'(cfg_wr_reject), 64'd0);
    endtask

    task automatic cfg_read(input int idx, input bit sel, output logic [31:0] d);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_idx = 3'(idx); cfg_sel = sel;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic request(input logic [23:0] fld, input logic [15:0] low,
                           input bit wr, input bit cpu);
        @(negedge clk);
        req_valid = 1'b1; req_addr = {fld, low}; req_is_write = wr; req_from_cpu = cpu;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input bit hit, input bit err,
                              input logic [2:0] node, input logic [1:0] link,
                              input bit np, input logic [2:0] rng);
        chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " hit"}, 64'(rsp_hit), 64'(hit));
        chk({tag, " error"}, 64'(rsp_error), 64'(err));
        chk({tag, " node"}, 64'(rsp_node), 64'(node));
        chk({tag, " link"}, 64'(rsp_link), 64'(link));
        chk({tag, " nonposted"}, 64'(rsp_nonposted), 64'(np));
        chk({tag, " range"}, 64'(rsp_range), 64'(rng));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 rdata", 64'(cfg_rdata), 64'd0);
        chk("R1 reject", 64'(cfg_wr_reject), 64'd0);
        chk("R1 valid", 64'(rsp_valid), 64'd0);
        chk("R1 hit", 64'(rsp_hit), 64'd0);
        cfg_read(3, 1'b0, d); chk("R1 base3", 64'(d), 64'd0);
        cfg_read(6, 1'b1, d); chk("R1 limit6", 64'(d), 64'd0);
        request(24'h000000, 16'h0, 1'b0, 1'b0);
        expect_rsp("R1 empty map", 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 3'd0);
    endtask

    task automatic t_bounds;
        cfg_write(0, 1'b1, mk_lim(24'h0010FF, 1'b0, 2'd1, 3'd5), 1'b0);
        cfg_write(0, 1'b0, mk_base(24'h001000, 1'b0, 1'b0, 1'b1, 1'b1), 1'b0);
        request(24'h001000, 16'h0000, 1'b0, 1'b0);
        expect_rsp("R2 R7 base edge", 1'b1, 1'b0, 3'd5, 2'd1, 1'b0, 3'd0);
        request(24'h0010FF, 16'hFFFF, 1'b1, 1'b0);
        expect_rsp("R2 limit edge", 1'b1, 1'b0, 3'd5, 2'd1, 1'b0, 3'd0);
        request(24'h000FFF, 16'hFFFF, 1'b0, 1'b0);
        expect_rsp("R2 below base", 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 3'd0);
        request(24'h001100, 16'h0000, 1'b0, 1'b0);
        expect_rsp("R2 above limit", 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 3'd0);
    endtask

    task automatic t_enables;
        cfg_write(1, 1'b1, mk_lim(24'h2000FF, 1'b0, 2'd2, 3'd3), 1'b0);
        cfg_write(1, 1'b0, mk_base(24'h200000, 1'b0, 1'b0, 1'b0, 1'b1), 1'b0);
        request(24'h200010, 16'h0, 1'b0, 1'b0);
        expect_rsp("R3 read enabled", 1'b1, 1'b0, 3'd3, 2'd2, 1'b0, 3'd1);
        request(24'h200010, 16'h0, 1'b1, 1'b0);
        expect_rsp("R3 write disabled", 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 3'd0);
        cfg_write(1, 1'b0, mk_base(24'h200000, 1'b0, 1'b0, 1'b1, 1'b0), 1'b0);
        request(24'h200010, 16'h0, 1'b1, 1'b0);
        expect_rsp("R3 write enabled", 1'b1, 1'b0, 3'd3, 2'd2, 1'b0, 3'd1);
        request(24'h200010, 16'h0, 1'b0, 1'b0);
        expect_rsp("R3 read disabled", 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 3'd0);
    endtask

    task automatic t_cpu_disable;
        cfg_write(2, 1'b1, mk_lim(24'h300000, 1'b0, 2'd0, 3'd6), 1'b0);
        cfg_write(2, 1'b0, mk_base(24'h300000, 1'b0, 1'b1, 1'b1, 1'b1), 1'b0);
        request(24'h300000, 16'h1234, 1'b0, 1'b1);
        expect_rsp("R4 cpu excluded", 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 3'd0);
        request(24'h300000, 16'h1234, 1'b0, 1'b0);
        expect_rsp("R4 non-cpu allowed", 1'b1, 1'b0, 3'd6, 2'd0, 1'b0, 3'd2);
    endtask

    task automatic t_nonposted;
        cfg_write(3, 1'b1, mk_lim(24'h4000FF, 1'b1, 2'd1, 3'd2), 1'b0);
        cfg_write(3, 1'b0, mk_base(24'h400000, 1'b0, 1'b0, 1'b1, 1'b1), 1'b0);
        request(24'h400001, 16'h0, 1'b1, 1'b1);
        expect_rsp("R9 cpu write", 1'b1, 1'b0, 3'd2, 2'd1, 1'b1, 3'd3);
        request(24'h400001, 16'h0, 1'b1, 1'b0);
        expect_rsp("R9 device write", 1'b1, 1'b0, 3'd2, 2'd1, 1'b0, 3'd3);
        request(24'h400001, 16'h0, 1'b0, 1'b1);
        expect_rsp("R9 cpu read", 1'b1, 1'b0, 3'd2, 2'd1, 1'b0, 3'd3);
    endtask

    task automatic t_reserved_link;
        cfg_write(4, 1'b1, mk_lim(24'h4800FF, 1'b1, 2'd3, 3'd7), 1'b0);
        cfg_write(4, 1'b0, mk_base(24'h480000, 1'b0, 1'b0, 1'b1, 1'b1), 1'b0);
        request(24'h480080, 16'h0, 1'b1, 1'b1);
        expect_rsp("R8 reserved link", 1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 3'd0);
    endtask

    task automatic t_priority;
        cfg_write(5, 1'b1, mk_lim(24'h5000FF, 1'b0, 2'd0, 3'd1), 1'b0);
        cfg_write(5, 1'b0, mk_base(24'h500000, 1'b0, 1'b0, 1'b1, 1'b1), 1'b0);
        cfg_write(6, 1'b1, mk_lim(24'h5000FF, 1'b0, 2'd2, 3'd4), 1'b0);
        cfg_write(6, 1'b0, mk_base(24'h500000, 1'b0, 1'b0, 1'b1, 1'b1), 1'b0);
        request(24'h500050, 16'h0, 1'b0, 1'b0);
        expect_rsp("R10 lower wins", 1'b1, 1'b0, 3'd1, 2'd0, 1'b0, 3'd5);
        cfg_write(5, 1'b0, mk_base(24'h500000, 1'b0, 1'b0, 1'b1, 1'b0), 1'b0);
        request(24'h500050, 16'h0, 1'b0, 1'b0);
        expect_rsp("R10 next in line", 1'b1, 1'b0, 3'd4, 2'd2, 1'b0, 3'd6);
    endtask

    task automatic t_lock;
        logic [31:0] d;
        cfg_write(7, 1'b1, mk_lim(24'h7000FF, 1'b0, 2'd2, 3'd3), 1'b0);
        cfg_write(7, 1'b0, mk_base(24'h700000, 1'b1, 1'b0, 1'b1, 1'b1), 1'b0);
        cfg_write(7, 1'b1, mk_lim(24'h7000FF, 1'b0, 2'd0, 3'd0), 1'b1);
        cfg_write(7, 1'b0, mk_base(24'h700000, 1'b0, 1'b0, 1'b0, 1'b0), 1'b1);
        cfg_read(7, 1'b1, d);
        chk("R5 limit kept", 64'(d), 64'(mk_lim(24'h7000FF, 1'b0, 2'd2, 3'd3)));
        cfg_read(7, 1'b0, d);
        chk("R5 base kept", 64'(d), 64'(mk_base(24'h700000, 1'b1, 1'b0, 1'b1, 1'b1)));
        request(24'h700000, 16'h0, 1'b0, 1'b0);
        expect_rsp("R5 routing kept", 1'b1, 1'b0, 3'd3, 2'd2, 1'b0, 3'd7);
    endtask

    task automatic t_timing;
        logic [31:0] d;
        @(negedge clk);
        chk("R11 idle valid", 64'(rsp_valid), 64'd0);
        chk("R11 idle hit", 64'(rsp_hit), 64'd0);
        cfg_read(0, 1'b1, d);
        chk("R11 read data", 64'(d), 64'(mk_lim(24'h0010FF, 1'b0, 2'd1, 3'd5)));
        @(negedge clk);
        chk("R11 rdata held", 64'(cfg_rdata), 64'(mk_lim(24'h0010FF, 1'b0, 2'd1, 3'd5)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bounds();
        t_enables();
        t_cpu_disable();
        t_nonposted();
        t_reserved_link();
        t_priority();
        t_lock();
        t_timing();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule